// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `N` bits and returns a signed product of `2N` bits. It uses modified Booth recoding and retires two multiplier bits per clock, so a full multiply takes `N/2` steps.

In each step the block reads three overlapping multiplier bits. For the first step an implied zero sits below bit 0. The recoded digit chooses 0, ±x or ±2x. That multiple, moved to weight 4^k for step k and sign-extended to the full product width, is added to a running sum by a single adder/subtracter.

A caller pulses `start` with both operands. After `N/2` clocks the block raises `done` for one cycle. The product then stays on its port until the next accepted start.

Top module: `booth_mul`

## Requirements
- R1: After reset, `done` is 0 and `product` is 0.
- R2: When `done` is high, `product` equals the signed product of the multiplicand and multiplier that were sampled with the accepted `start`, over all pairs including -2^(N-1) × -2^(N-1).
- R3: A `start` sampled high at clock edge E while the block is idle is accepted. `done` is then high for exactly the one cycle that follows edge E+N/2 and low in every other cycle.
- R4: Once `done` has been raised, `product` holds its value until the next accepted `start`, whatever the operand inputs do in the meantime.
- R5: A `start` that arrives while a multiply is in progress is ignored. It alters neither the result nor the cycle in which `done` rises, and operand changes after the accepted `start` have no effect.
- R6: During a multiply, `product` shows the running sum after each step. The 3-bit window {y[2k+1], y[2k], y[2k-1]} with y[-1]=0 adds 0 for 000 and 111, +x for 001 and 010, +2x for 011, -2x for 100, and -x for 101 and 110, all times 4^k. For x=25 and y=-18 the running sums are -50, -50, -450, -450.
- R7: A `start` sampled in the same cycle that `done` is high is accepted as a new multiply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiply when idle |
| multiplicand | input | N | Signed operand x |
| multiplier | input | N | Signed operand y, recoded two bits per step |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2N | Signed running sum, final while `done` is high and held afterwards |

## Verification
Directed sweeps fix one operand at -128, -127, -1, 0, 1 or 127 and run every value of the other. These sweeps reach each recoding window at every step position, together with the most negative multiple and the -128 × -128 overflow case that a narrower sum would get wrong. Random pairs, biased toward extreme values, cover carry and sign-extension paths inside the word. The 25 × -18 case is compared step by step against the table in R6. It separates a wrong digit choice from a wrong alignment, which can cancel each other in a final value. Back-to-back, interrupted and idle-hold sequences test the timing of `done` and the point at which operands are captured.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands, clear the sum
    logic step;   // perform one recoding step
    logic last;   // current step is the final one
  } ctlStrobes_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder (
  input  logic [2:0] window,
  output logic       isZero,
  output logic       isTwo,
  output logic       isNeg
);
  always_comb begin
    isZero = 1'b0;
    isTwo  = 1'b0;
    isNeg  = 1'b0;
    unique case (window)
      3'b000, 3'b111: isZero = 1'b1;
      3'b001, 3'b010: ;
      3'b011:         isTwo = 1'b1;
      3'b100:         begin isTwo = 1'b1; isNeg = 1'b1; end
      3'b101, 3'b110: isNeg = 1'b1;
      default:        isZero = 1'b1;
    endcase
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctlStrobes_t ctl,
  output logic        done
);
  localparam int STEPS = N / 2;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic          busy;
  logic [CW-1:0] stepCnt;

  always_comb begin
    ctl.load = start & ~busy;
    ctl.step = busy;
    ctl.last = busy & (stepCnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= ctl.step & ctl.last;
      if (ctl.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (busy) begin
        if (ctl.last) busy <= 1'b0;
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  // R3: done is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: done only follows a step
  assert_done_after_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  // R5: a start during a multiply does not restart the count
  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !ctl.last) |=> (busy && stepCnt == $past(stepCnt) + 1'b1));

  // R5: load and step never coincide
  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.step}));
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   ctl,
  input  logic [N-1:0]  xIn,
  input  logic [N-1:0]  yIn,
  output logic [2*N-1:0] sumOut
);
  localparam int P = 2 * N;

  logic [P-1:0] acc;
  logic [P-1:0] mcand;    // sign-extended x, aligned to current step weight
  logic [N:0]   yShift;   // multiplier with implied zero below bit 0

  logic         isZero, isTwo, isNeg;
  logic [P-1:0] multiple;
  logic [P-1:0] addend;
  logic         carryIn;

  booth_recoder u_rec (
    .window (yShift[2:0]),
    .isZero (isZero),
    .isTwo  (isTwo),
    .isNeg  (isNeg)
  );

  always_comb begin
    multiple = isTwo ? {mcand[P-2:0], 1'b0} : mcand;
    addend   = isZero ? '0 : (isNeg ? ~multiple : multiple);
    carryIn  = isNeg & ~isZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      mcand  <= '0;
      yShift <= '0;
    end else if (ctl.load) begin
      acc    <= '0;
      mcand  <= {{N{xIn[N-1]}}, xIn};
      yShift <= {yIn, 1'b0};
    end else if (ctl.step) begin
      acc    <= acc + addend + P'(carryIn);
      mcand  <= {mcand[P-3:0], 2'b00};
      yShift <= {{2{yShift[N]}}, yShift[N:2]};
    end
  end

  assign sumOut = acc;

  // R4: the sum holds whenever no load or step is in flight
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> $stable(acc));

  // R6: a zero digit leaves the running sum unchanged
  assert_zero_digit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && isZero) |=> acc == $past(acc));

  // R1: a load clears the running sum
  assert_load_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> acc == '0);
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic           done,
  output logic [2*N-1:0] product
);
  ctlStrobes_t ctl;

  booth_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .done  (done)
  );

  booth_datapath #(.N(N)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .xIn    (multiplicand),
    .yIn    (multiplier),
    .sumOut (product)
  );
endmodule

// File: tb/booth_mul_test.sv
module booth_mul_test;
  localparam int N     = 8;
  localparam int STEPS = N / 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   xIn = '0;
  logic [N-1:0]   yIn = '0;
  logic           done;
  logic [2*N-1:0] product;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  booth_mul #(.N(N)) uut (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .multiplicand (xIn),
    .multiplier   (yIn),
    .done         (done),
    .product      (product)
  );

  function automatic logic [2*N-1:0] expProd(logic [N-1:0] a, logic [N-1:0] b);
    logic signed [2*N-1:0] sa, sb;
    sa = {{N{a[N-1]}}, a};
    sb = {{N{b[N-1]}}, b};
    return sa * sb;
  endfunction

  task automatic chk(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Start at a negedge; returns at the negedge where done is expected.
  task automatic runOp(logic [N-1:0] a, logic [N-1:0] b);
    start = 1'b1; xIn = a; yIn = b;
    @(negedge clk);
    start = 1'b0;
    xIn = N'($urandom); yIn = N'($urandom);  // R5: late operand changes ignored
    for (int i = 1; i < STEPS; i++) begin
      chk("R3 done low mid-run", {{(2*N-1){1'b0}}, done}, '0);
      @(negedge clk);
    end
    chk("R3 done low mid-run", {{(2*N-1){1'b0}}, done}, '0);
    @(negedge clk);
    chk("R3 done pulse", {{(2*N-1){1'b0}}, done}, {{(2*N-1){1'b0}}, 1'b1});
    chk("R2 product", product, expProd(a, b));
  endtask

  initial begin
    logic [N-1:0] a, b;
    logic [2*N-1:0] held;
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset done", {{(2*N-1){1'b0}}, done}, '0);
    chk("R1 reset product", product, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R6: running sums for 25 x -18
    start = 1'b1; xIn = 8'd25; yIn = 8'hEE;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk); chk("R6 step1", product, 16'hFFCE);
    @(negedge clk); chk("R6 step2", product, 16'hFFCE);
    @(negedge clk); chk("R6 step3", product, 16'hFE3E);
    @(negedge clk); chk("R6 step4", product, 16'hFE3E);
    chk("R3 done for example", {{(2*N-1){1'b0}}, done}, 16'd1);
    @(negedge clk);
    chk("R3 done falls", {{(2*N-1){1'b0}}, done}, '0);

    // R7: -128 x -128, then back-to-back start in the done cycle
    runOp(8'h80, 8'h80);
    chk("R2 min times min", product, 16'd16384);
    runOp(8'h80, 8'h7F);
    runOp(8'h7F, 8'h80);
    @(negedge clk);

    // R4: hold while idle with operands toggling
    runOp(8'hC3, 8'h5A);
    held = product;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      xIn = N'($urandom); yIn = N'($urandom);
      chk("R4 hold", product, held);
      chk("R3 done stays low", {{(2*N-1){1'b0}}, done}, '0);
    end

    // R5: start while busy ignored
    start = 1'b1; xIn = 8'd77; yIn = 8'hB1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; xIn = 8'h80; yIn = 8'h80;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 done timing", {{(2*N-1){1'b0}}, done}, 16'd1);
    chk("R5 first result kept", product, expProd(8'd77, 8'hB1));
    @(negedge clk);
    chk("R5 no second done", {{(2*N-1){1'b0}}, done}, '0);
    @(negedge clk);

    // R2: sweeps with one operand pinned at an extreme
    foreach (a[k]) ;
    for (int e = 0; e < 6; e++) begin
      logic [N-1:0] ext;
      case (e)
        0: ext = 8'h80; 1: ext = 8'h81; 2: ext = 8'hFF;
        3: ext = 8'h00; 4: ext = 8'h01; default: ext = 8'h7F;
      endcase
      for (int v = 0; v < 256; v++) begin
        runOp(ext, N'(v));
        runOp(N'(v), ext);
      end
    end

    // R2: biased random pairs
    for (int i = 0; i < 4000; i++) begin
      a = N'($urandom);
      b = N'($urandom);
      if ($urandom_range(3) == 0) a = ($urandom_range(1) == 0) ? 8'h80 : 8'h7F;
      if ($urandom_range(3) == 0) b = ($urandom_range(1) == 0) ? 8'h80 : 8'hFF;
      runOp(a, b);
    end

    @(negedge clk);
    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule